// File: doc/BRIEF.md
# Tree-Structured Unsigned Magnitude Comparator

This block orders two unsigned operands of `WIDTH` bits and raises exactly one of three flags: less-than, equal or greater-than. Each bit position is first reduced to a pair of bits. One bit says "this position alone makes A smaller" and the other says "the two bits match". Adjacent groups are then combined level by level, in the way a carry-lookahead adder combines generate and propagate terms. After log2(WIDTH) levels, one pair covers the whole operand. The greater-than flag is not computed by the tree. It is derived as "neither smaller nor equal".

A parameter lets alternate merge levels carry their pair in inverted form, with the next level written to accept inverted inputs. The output stage restores true polarity whatever the parity of the last level. Another parameter adds a register stage on the three flags, with a synchronous active-high reset. With that stage present, a comparison becomes visible one rising edge after its operands.

Top module: `cmp_tree_top`

## Requirements
- R1: `a_lt_b` is 1 exactly when `a` is smaller than `b`, both read as unsigned numbers.
- R2: `a_eq_b` is 1 exactly when every bit of `a` matches the same bit of `b`.
- R3: `a_gt_b` is 1 exactly when `a` is larger than `b`. Outside reset, exactly one of the three flags is 1.
- R4: When the operands differ in several positions, the highest-index differing position alone decides the result. Bit `WIDTH-1` is the most significant.
- R5: A difference confined to bit 0 is resolved correctly in both directions, so the lowest position reaches the result through every level.
- R6: A difference confined to bit `WIDTH-1` is resolved correctly in both directions, including all-zeros against all-ones.
- R7: No group at any merge level ever reports "smaller" and "equal" at the same time.
- R8: With `ALT_POLARITY` = 1, every output matches the same design built with `ALT_POLARITY` = 0 for any operands.
- R9: With `REG_OUT` = 1, the flags change only on a rising clock edge, and they show the operands present just before that edge.
- R10: While `rst` is 1 at a rising edge, and `REG_OUT` = 1, all three flags are cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| a_lt_b | output | 1 | `a` is smaller than `b` |
| a_eq_b | output | 1 | `a` equals `b` |
| a_gt_b | output | 1 | `a` is larger than `b` |

## Verification
The hardest case to reach from the ports is a long chain of "equal" groups that carries a decision from a single low-order position all the way to the root. Random operands almost never match in the upper 63 bits. The stimulus therefore uses one-hot operands, equal operands with a single flipped bit at each position in turn, and pairs whose top bits agree while the lower bits disagree in opposite directions. A second instance built with true polarity at every level runs beside the default instance, so an error in the inverted-level decoding shows up as a mismatch on the same vector.

// File: rtl/cmp_tree_pkg.sv
package cmp_tree_pkg;

  // Pair layout used across the tree: bit 1 = "smaller", bit 0 = "equal".
  function automatic logic [1:0] enc_bit(logic abit, logic bbit);
    return {(~abit) & bbit, ~(abit ^ bbit)};
  endfunction

  // The high group decides; the low group is consulted only when the high group ties.
  function automatic logic [1:0] merge_pair(logic [1:0] hi, logic [1:0] lo);
    return {hi[1] | (hi[0] & lo[1]), hi[0] & lo[0]};
  endfunction

  // Merge level k carries inverted pairs when alternation is on and k is even.
  function automatic bit level_inverted(bit alt, int unsigned k);
    return alt && ((k % 2) == 0);
  endfunction

endpackage

// File: rtl/cmp_bit_encode.sv
module cmp_bit_encode #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] lt_bit,
  output logic [WIDTH-1:0] eq_bit
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] pair;
    assign pair      = cmp_tree_pkg::enc_bit(a[i], b[i]);
    assign lt_bit[i] = pair[1];
    assign eq_bit[i] = pair[0];
  end
endmodule

// File: rtl/cmp_merge_level.sv
module cmp_merge_level #(
  parameter int N_IN    = 64,
  parameter bit IN_INV  = 1'b0,
  parameter bit OUT_INV = 1'b0,
  localparam int N_OUT  = N_IN / 2
) (
  input  logic [N_IN-1:0]  lt_i,
  input  logic [N_IN-1:0]  eq_i,
  output logic [N_OUT-1:0] lt_o,
  output logic [N_OUT-1:0] eq_o
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_grp
    logic [1:0] hi_raw, lo_raw, hi, lo, res;
    assign hi_raw  = {lt_i[2*j+1], eq_i[2*j+1]};
    assign lo_raw  = {lt_i[2*j],   eq_i[2*j]};
    // inputs arriving in inverted form are restored before the merge
    assign hi      = IN_INV ? ~hi_raw : hi_raw;
    assign lo      = IN_INV ? ~lo_raw : lo_raw;
    assign res     = cmp_tree_pkg::merge_pair(hi, lo);
    assign lt_o[j] = OUT_INV ? ~res[1] : res[1];
    assign eq_o[j] = OUT_INV ? ~res[0] : res[0];
  end
endmodule

// File: rtl/cmp_out_stage.sv
module cmp_out_stage #(
  parameter bit IN_INV  = 1'b0,
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lt_i,
  input  logic eq_i,
  output logic lt_o,
  output logic eq_o,
  output logic gt_o
);
  logic lt_t, eq_t, gt_t;
  assign lt_t = IN_INV ? ~lt_i : lt_i;
  assign eq_t = IN_INV ? ~eq_i : eq_i;
  assign gt_t = ~lt_t & ~eq_t;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        lt_o <= 1'b0;
        eq_o <= 1'b0;
        gt_o <= 1'b0;
      end else begin
        lt_o <= lt_t;
        eq_o <= eq_t;
        gt_o <= gt_t;
      end
    end
  end else begin : g_comb
    assign lt_o = lt_t;
    assign eq_o = eq_t;
    assign gt_o = gt_t;
  end
endmodule

// File: rtl/cmp_tree_top.sv
module cmp_tree_top #(
  parameter int WIDTH        = 64,
  parameter bit ALT_POLARITY = 1'b1,
  parameter bit REG_OUT      = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             a_lt_b,
  output logic             a_eq_b,
  output logic             a_gt_b
);
  localparam int LEVELS   = $clog2(WIDTH);
  localparam bit LAST_INV = cmp_tree_pkg::level_inverted(ALT_POLARITY, LEVELS - 1);

  initial begin
    if (WIDTH < 2 || (1 << LEVELS) != WIDTH)
      $error("cmp_tree_top: WIDTH must be a power of two of at least 2");
  end

  logic [WIDTH-1:0] enc_lt, enc_eq;

  cmp_bit_encode #(.WIDTH(WIDTH)) u_enc (
    .a(a), .b(b), .lt_bit(enc_lt), .eq_bit(enc_eq)
  );

  for (genvar k = 0; k < LEVELS; k++) begin : lvl
    localparam int NI      = WIDTH >> k;
    localparam int NO      = NI / 2;
    localparam bit INV_OUT = cmp_tree_pkg::level_inverted(ALT_POLARITY, k);
    localparam bit INV_IN  = (k == 0) ? 1'b0
                           : cmp_tree_pkg::level_inverted(ALT_POLARITY, k - 1);
    logic [NI-1:0] lt_in, eq_in;
    logic [NO-1:0] lt_out, eq_out;
    logic [NO-1:0] lt_t, eq_t;   // true-polarity view of this level, for checks

    if (k == 0) begin : g_first
      assign lt_in = enc_lt;
      assign eq_in = enc_eq;
    end else begin : g_rest
      assign lt_in = lvl[k-1].lt_out;
      assign eq_in = lvl[k-1].eq_out;
    end

    cmp_merge_level #(.N_IN(NI), .IN_INV(INV_IN), .OUT_INV(INV_OUT)) u_lvl (
      .lt_i(lt_in), .eq_i(eq_in), .lt_o(lt_out), .eq_o(eq_out)
    );

    assign lt_t = INV_OUT ? ~lt_out : lt_out;
    assign eq_t = INV_OUT ? ~eq_out : eq_out;

    // R7
    no_lt_and_eq_chk: assert property (@(posedge clk) disable iff (rst)
      ((lt_t & eq_t) == '0));
  end

  logic root_lt, root_eq, root_lt_t, root_eq_t;
  assign root_lt   = lvl[LEVELS-1].lt_out[0];
  assign root_eq   = lvl[LEVELS-1].eq_out[0];
  assign root_lt_t = lvl[LEVELS-1].lt_t[0];
  assign root_eq_t = lvl[LEVELS-1].eq_t[0];

  cmp_out_stage #(.IN_INV(LAST_INV), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst), .lt_i(root_lt), .eq_i(root_eq),
    .lt_o(a_lt_b), .eq_o(a_eq_b), .gt_o(a_gt_b)
  );

  // R1
  root_lt_matches_chk: assert property (@(posedge clk) disable iff (rst)
    root_lt_t == (a < b));

  // R2
  root_eq_matches_chk: assert property (@(posedge clk) disable iff (rst)
    root_eq_t == (a == b));

  if (REG_OUT) begin : g_reg_chk
    // R3
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $onehot({a_lt_b, a_eq_b, a_gt_b}));
    // R9
    reg_follows_tree_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (a_lt_b == $past(root_lt_t)) && (a_eq_b == $past(root_eq_t)));
  end else begin : g_comb_chk
    // R3
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot({a_lt_b, a_eq_b, a_gt_b}));
  end
endmodule

// File: tb/cmp_tree_top_tb.sv
module cmp_tree_top_tb;
  localparam int W = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic lt, eq, gt, lt_f, eq_f, gt_f;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  cmp_tree_top #(.WIDTH(W), .ALT_POLARITY(1'b1), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .a(a), .b(b), .a_lt_b(lt), .a_eq_b(eq), .a_gt_b(gt)
  );

  cmp_tree_top #(.WIDTH(W), .ALT_POLARITY(1'b0), .REG_OUT(1'b1)) u_dut_flat (
    .clk(clk), .rst(rst), .a(a), .b(b), .a_lt_b(lt_f), .a_eq_b(eq_f), .a_gt_b(gt_f)
  );

  task automatic check3(string req, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got={lt,eq,gt}=%b expected=%b a=%h b=%h", req, got, exp, a, b);
    end
  endtask

  // Drive at the falling edge, let one rising edge register it, sample 2 ns later.
  task automatic apply(string req, logic [W-1:0] x, logic [W-1:0] y);
    logic [2:0] exp;
    @(negedge clk);
    a = x;
    b = y;
    @(posedge clk);
    #2;
    exp = {x < y, x == y, x > y};
    check3(req, {lt, eq, gt}, exp);
    check3("R8", {lt_f, eq_f, gt_f}, {lt, eq, gt});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    a = '0;
    b = 64'd1;
    repeat (3) @(posedge clk);
    #2;
    check3("R10", {lt, eq, gt}, 3'b000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_equal();
    apply("R2", '0, '0);
    apply("R2", '1, '1);
    apply("R2", 64'hA5A5_0F0F_1234_8001, 64'hA5A5_0F0F_1234_8001);
  endtask

  task automatic t_bit0();
    apply("R5", 64'h0, 64'h1);
    apply("R5", 64'h1, 64'h0);
    apply("R5", 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF);
    apply("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic t_bit63();
    apply("R6", 64'h8000_0000_0000_0000, 64'h0);
    apply("R6", 64'h0, 64'h8000_0000_0000_0000);
    apply("R6", '0, '1);
    apply("R6", '1, '0);
  endtask

  task automatic t_priority();
    // top half decides against a lower half pointing the other way
    apply("R4", 64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0000);
    apply("R4", 64'h0000_0002_0000_0000, 64'h0000_0001_FFFF_FFFF);
    apply("R4", 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    apply("R4", 64'hDEAD_BEEF_0000_0010, 64'hDEAD_BEEF_0000_000F);
  endtask

  task automatic t_onehot_sweep();
    for (int i = 0; i < W; i++) begin
      apply("R1", '0, 64'd1 << i);
      apply("R3", 64'd1 << i, '0);
      // equal operands with a single flipped position: a long tie chain
      apply("R4", 64'h5A5A_5A5A_5A5A_5A5A ^ (64'd1 << i), 64'h5A5A_5A5A_5A5A_5A5A);
    end
  endtask

  task automatic t_random();
    for (int n = 0; n < 150; n++) begin
      logic [W-1:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (n % 3 == 1) y[W-1:16] = x[W-1:16];
      if (n % 3 == 2) y = x ^ (64'd1 << ($urandom % W));
      apply((x < y) ? "R1" : "R3", x, y);
    end
  endtask

  task automatic t_latency();
    apply("R9", 64'd3, 64'd9);
    @(negedge clk);
    a = 64'd5;
    b = 64'd5;
    #1;
    check3("R9", {lt, eq, gt}, 3'b100);   // no edge yet: old result held
    @(posedge clk);
    #2;
    check3("R9", {lt, eq, gt}, 3'b010);
  endtask

  task automatic t_mid_reset();
    apply("R3", 64'd10, 64'd2);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check3("R10", {lt, eq, gt}, 3'b000);
    check3("R10", {lt_f, eq_f, gt_f}, 3'b000);
    @(negedge clk);
    rst = 1'b0;
    apply("R3", 64'd10, 64'd2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_equal();
    t_bit0();
    t_bit63();
    t_priority();
    t_onehot_sweep();
    t_random();
    t_latency();
    t_mid_reset();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule